// File: doc/BRIEF.md
# PCM Clock-Domain Command Bridge

This block carries control commands from the system clock domain into a PCM bit-clock domain and returns their results. Three kinds of command cross it. An echo bit shows that the PCM clock is running: software writes a value and reads it back once the PCM domain has taken it up. Two FIFO-clear requests, one for transmit and one for receive, each produce a single clear pulse in the PCM domain. They stay visible as pending bits until the PCM side has acknowledged them, and then clear themselves. A standby-release level wakes the PCM side, which only counts itself awake after a fixed number of its own clocks.

Two FIFO status flags travel the other way, from the PCM domain to the control domain: transmit FIFO empty and receive data present. Every crossing uses multi-flop synchronizers, and each clear uses a toggle request with a toggle acknowledge. A clear request therefore survives any ratio between the two clock frequencies, and it waits while the PCM clock is stopped. FIFO clears are meant to be issued while the transmit and receive enables are off, and the enables are restored afterwards. That sequencing belongs to the caller.

Top module: `pcm_ctl_sync`

## Requirements
- R1: After reset every output is 0.
- R2: A value written with `sync_wr_i` does not appear on `sync_rd_o` until the second PCM clock edge after the capturing system edge has passed. It appears by the sixth PCM edge.
- R3: A clear request sets its pending bit (`txclr_o` or `rxclr_o`) on the system edge that captures it. The bit stays 1 until at least two PCM edges have passed, and it returns to 0 by the sixth PCM edge.
- R4: Each accepted clear request gives exactly one pulse on its PCM-domain output, one PCM cycle wide. Transmit and receive requests act independently and may be issued in the same cycle.
- R5: A clear request that arrives while the same channel is still pending is ignored. It gives no extra pulse, and the pending bit still clears within the window of the first request.
- R6: While the PCM clock is stopped, a pending clear and a new echo value stay held. Both complete once the clock resumes.
- R7: After `stby_rel_i` rises, `pcm_awake_o` stays 0 for the first six PCM edges and is 1 by the eighth. `stby_ready_o` stays 0 for the first six PCM edges and is 1 by the ninth.
- R8: After `stby_rel_i` falls, `pcm_awake_o` is still 1 through the second PCM edge and is 0 by the third. `stby_ready_o` is 0 by the fourth.
- R9: `txempty_o` and `rxdata_o` follow `pcm_txempty_i` and `pcm_rxdata_i` within two PCM edges of a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | System-domain reset, active low |
| pcm_clk_i | input | 1 | PCM bit clock |
| pcm_rst_ni | input | 1 | PCM-domain reset, active low |
| sync_wr_i | input | 1 | Write strobe for the echo bit |
| sync_val_i | input | 1 | Value to write to the echo bit |
| sync_rd_o | output | 1 | Echo value returned from the PCM domain |
| txclr_set_i | input | 1 | Request a transmit FIFO clear |
| rxclr_set_i | input | 1 | Request a receive FIFO clear |
| txclr_o | output | 1 | Transmit clear pending |
| rxclr_o | output | 1 | Receive clear pending |
| stby_rel_i | input | 1 | Standby release level |
| stby_ready_o | output | 1 | PCM side awake, seen in the system domain |
| txempty_o | output | 1 | Transmit FIFO empty, synchronized |
| rxdata_o | output | 1 | Receive data present, synchronized |
| pcm_txclr_o | output | 1 | One-cycle transmit clear pulse, PCM domain |
| pcm_rxclr_o | output | 1 | One-cycle receive clear pulse, PCM domain |
| pcm_awake_o | output | 1 | PCM side awake, PCM domain |
| pcm_txempty_i | input | 1 | Transmit FIFO empty, PCM domain |
| pcm_rxdata_i | input | 1 | Receive data present, PCM domain |

## Verification
The hardest case to reach is a request that is still in flight while the PCM clock stands still. Pending state must then hold for an unbounded time and still complete exactly once when the clock returns. The bench gates the PCM clock while it is low. It issues a receive clear and a new echo value into the stopped domain and holds the stop for a hundred system cycles. The reference model counts PCM edges, so the stopped clock freezes its expectations as well. The bench then releases the clock and checks for a single pulse and for the echo arriving. Back-to-back requests on one channel, and simultaneous transmit and receive requests, exercise the ignore rule and the independence of the two channels.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // System-side state of one clear channel
    typedef struct packed {
        logic pend;
        logic req;
    } clr_ctl_t;

    // System-side state of the top level
    typedef struct packed {
        logic echo_val;
    } top_ctl_t;

endpackage

// File: rtl/pcs_bitsync.sv
module pcs_bitsync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] ff_d, ff_q;

    always_comb begin
        ff_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            ff_d[i] = ff_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pcs_clr_chan.sv
module pcs_clr_chan
    import pcs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    output logic pend_o,
    input  logic pcm_clk_i,
    input  logic pcm_rst_ni,
    output logic pcm_pulse_o
);
    clr_ctl_t ctl_d, ctl_q;
    logic     ack_s;
    logic     req_s;
    logic     ack_d, ack_q;

    // System side: toggle a request, wait for a matching acknowledge
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.pend) begin
            if (ack_s == ctl_q.req) ctl_d.pend = 1'b0;
        end else if (set_i) begin
            ctl_d.pend = 1'b1;
            ctl_d.req  = ~ctl_q.req;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    pcs_bitsync #(.WIDTH(1), .STAGES(STAGES)) i_req_sync (
        .clk_i  (pcm_clk_i),
        .rst_ni (pcm_rst_ni),
        .d_i    (ctl_q.req),
        .q_o    (req_s)
    );

    // PCM side: an edge on the synchronized request is one clear pulse
    always_comb begin
        ack_d = req_s;
    end

    always_ff @(posedge pcm_clk_i or negedge pcm_rst_ni) begin
        if (!pcm_rst_ni) ack_q <= 1'b0;
        else             ack_q <= ack_d;
    end

    pcs_bitsync #(.WIDTH(1), .STAGES(STAGES)) i_ack_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ack_q),
        .q_o    (ack_s)
    );

    assign pend_o      = ctl_q.pend;
    assign pcm_pulse_o = req_s ^ ack_q;

    assert_idle_balanced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_q.pend |-> (ctl_q.req == ack_s));
    assert_pend_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.pend && (ack_s != ctl_q.req)) |=> ctl_q.pend);
    assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.pend && set_i) |=> $stable(ctl_q.req));
    assert_single_pulse_R4: assert property (@(posedge pcm_clk_i) disable iff (!pcm_rst_ni)
        pcm_pulse_o |=> !pcm_pulse_o);
endmodule

// File: rtl/pcs_wake.sv
module pcs_wake #(
    parameter int STAGES = 2,
    parameter int WAKE   = 4
) (
    input  logic pcm_clk_i,
    input  logic pcm_rst_ni,
    input  logic rel_i,
    output logic awake_o
);
    localparam int CNT_W = $clog2(WAKE + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             awake;
    } wake_t;

    wake_t w_d, w_q;
    logic  rel_s;

    pcs_bitsync #(.WIDTH(1), .STAGES(STAGES)) i_rel_sync (
        .clk_i  (pcm_clk_i),
        .rst_ni (pcm_rst_ni),
        .d_i    (rel_i),
        .q_o    (rel_s)
    );

    // Count WAKE PCM clocks of a held release before reporting awake
    always_comb begin
        w_d = w_q;
        if (!rel_s) begin
            w_d.cnt   = '0;
            w_d.awake = 1'b0;
        end else begin
            if (w_q.cnt != CNT_W'(WAKE)) w_d.cnt = w_q.cnt + 1'b1;
            w_d.awake = (w_q.cnt == CNT_W'(WAKE));
        end
    end

    always_ff @(posedge pcm_clk_i or negedge pcm_rst_ni) begin
        if (!pcm_rst_ni) w_q <= '0;
        else             w_q <= w_d;
    end

    assign awake_o = w_q.awake;

    assert_sleep_drop_R8: assert property (@(posedge pcm_clk_i) disable iff (!pcm_rst_ni)
        !rel_s |=> !w_q.awake);
    assert_wake_needs_rel_R7: assert property (@(posedge pcm_clk_i) disable iff (!pcm_rst_ni)
        $rose(w_q.awake) |-> $past(rel_s));
endmodule

// File: rtl/pcm_ctl_sync.sv
module pcm_ctl_sync
    import pcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pcm_clk_i,
    input  logic pcm_rst_ni,
    input  logic sync_wr_i,
    input  logic sync_val_i,
    output logic sync_rd_o,
    input  logic txclr_set_i,
    input  logic rxclr_set_i,
    output logic txclr_o,
    output logic rxclr_o,
    input  logic stby_rel_i,
    output logic stby_ready_o,
    output logic txempty_o,
    output logic rxdata_o,
    output logic pcm_txclr_o,
    output logic pcm_rxclr_o,
    output logic pcm_awake_o,
    input  logic pcm_txempty_i,
    input  logic pcm_rxdata_i
);
    localparam int NCLR = 2;
    localparam int NSTAT = 3;

    top_ctl_t         top_d, top_q;
    logic             echo_pcm;
    logic             awake_pcm;
    logic [NCLR-1:0]  clr_set, clr_pend, clr_pulse;
    logic [NSTAT-1:0] stat_s;

    always_comb begin
        top_d = top_q;
        if (sync_wr_i) top_d.echo_val = sync_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    // Echo goes out through the PCM domain and comes back
    pcs_bitsync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_echo_fwd (
        .clk_i  (pcm_clk_i),
        .rst_ni (pcm_rst_ni),
        .d_i    (top_q.echo_val),
        .q_o    (echo_pcm)
    );

    pcs_bitsync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_echo_back (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (echo_pcm),
        .q_o    (sync_rd_o)
    );

    // Index 0 is transmit, index 1 is receive
    assign clr_set = {rxclr_set_i, txclr_set_i};

    for (genvar g = 0; g < NCLR; g++) begin : g_clr
        pcs_clr_chan #(.STAGES(SYNC_STAGES)) i_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .set_i       (clr_set[g]),
            .pend_o      (clr_pend[g]),
            .pcm_clk_i   (pcm_clk_i),
            .pcm_rst_ni  (pcm_rst_ni),
            .pcm_pulse_o (clr_pulse[g])
        );
    end

    assign txclr_o     = clr_pend[0];
    assign rxclr_o     = clr_pend[1];
    assign pcm_txclr_o = clr_pulse[0];
    assign pcm_rxclr_o = clr_pulse[1];

    pcs_wake #(.STAGES(SYNC_STAGES), .WAKE(WAKE_CYCLES)) i_wake (
        .pcm_clk_i  (pcm_clk_i),
        .pcm_rst_ni (pcm_rst_ni),
        .rel_i      (stby_rel_i),
        .awake_o    (awake_pcm)
    );

    assign pcm_awake_o = awake_pcm;

    pcs_bitsync #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES)) i_stat_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({awake_pcm, pcm_txempty_i, pcm_rxdata_i}),
        .q_o    (stat_s)
    );

    assign stby_ready_o = stat_s[2];
    assign txempty_o    = stat_s[1];
    assign rxdata_o     = stat_s[0];

    assert_echo_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_wr_i |=> $stable(top_q.echo_val));
endmodule

// File: tb/test_pcm_ctl_sync.sv
`timescale 1ns/1ps
module test_pcm_ctl_sync;
    logic clk = 1'b0;
    logic pcm_raw = 1'b0;
    logic pcm_run = 1'b1;
    logic pcm_clk;
    logic rst_n = 1'b0, pcm_rst_n = 1'b0;
    logic sync_wr = 0, sync_val = 0, txset = 0, rxset = 0, stby = 0;
    logic ptxe = 0, prxd = 0;
    logic sync_rd, txclr, rxclr, ready, txe, rxd, ptxclr, prxclr, awake;

    int vectors = 0, fails = 0;
    int pe = 0;
    int tx_pulses = 0, rx_pulses = 0;
    logic ptx_prev = 0, prx_prev = 0;
    logic chk_en = 0;

    // channels: 0 echo, 1 txclr, 2 rxclr, 3 awake, 4 ready, 5 txempty, 6 rxdata
    int   pe0 [7];
    logic oldv[7];
    logic newv[7];
    int   lo  [7];
    int   hi  [7];
    string tag[7];

    always #2.5 clk = ~clk;
    initial begin
        #2;
        forever #10 pcm_raw = ~pcm_raw;
    end
    assign pcm_clk = pcm_raw & pcm_run;

    pcm_ctl_sync i_pcm_ctl_sync (
        .clk_i(clk), .rst_ni(rst_n), .pcm_clk_i(pcm_clk), .pcm_rst_ni(pcm_rst_n),
        .sync_wr_i(sync_wr), .sync_val_i(sync_val), .sync_rd_o(sync_rd),
        .txclr_set_i(txset), .rxclr_set_i(rxset), .txclr_o(txclr), .rxclr_o(rxclr),
        .stby_rel_i(stby), .stby_ready_o(ready), .txempty_o(txe), .rxdata_o(rxd),
        .pcm_txclr_o(ptxclr), .pcm_rxclr_o(prxclr), .pcm_awake_o(awake),
        .pcm_txempty_i(ptxe), .pcm_rxdata_i(prxd)
    );

    always @(posedge pcm_clk) begin
        pe <= pe + 1;
        if (ptxclr) tx_pulses <= tx_pulses + 1;
        if (prxclr) rx_pulses <= rx_pulses + 1;
        if (pcm_rst_n && ((ptxclr && ptx_prev) || (prxclr && prx_prev))) begin
            vectors <= vectors + 1;
            fails   <= fails + 1;
            $display("FAIL R4: clear pulse wider than one PCM cycle act=1 exp=0");
        end
        ptx_prev <= ptxclr;
        prx_prev <= prxclr;
    end

    function automatic logic act(int ch);
        case (ch)
            0: return sync_rd;
            1: return txclr;
            2: return rxclr;
            3: return awake;
            4: return ready;
            5: return txe;
            default: return rxd;
        endcase
    endfunction

    task automatic check(string req, logic a, logic e);
        vectors++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s: act=%0b exp=%0b at %0t", req, a, e, $time);
        end
    endtask

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (chk_en) begin
            for (int ch = 0; ch < 7; ch++) begin
                int d;
                d = pe - pe0[ch];
                if (d < lo[ch])       check(tag[ch], act(ch), oldv[ch]);
                else if (d >= hi[ch]) check(tag[ch], act(ch), newv[ch]);
            end
        end
    end

    task automatic set_ch(int ch, logic o, logic n, int l, int h, string t);
        oldv[ch] = o; newv[ch] = n; lo[ch] = l; hi[ch] = h; pe0[ch] = pe; tag[ch] = t;
    endtask

    task automatic wr_echo(logic v);
        @(posedge clk); #1;
        sync_wr = 1; sync_val = v;
        @(posedge clk);
        set_ch(0, newv[0], v, 2, 6, "R2");
        #1 sync_wr = 0;
    endtask

    task automatic clr_req(logic t, logic r);
        @(posedge clk); #1;
        txset = t; rxset = r;
        @(posedge clk);
        // a request on a channel still pending is ignored (R5)
        if (t && !(oldv[1] && (pe - pe0[1] < 2))) set_ch(1, 1'b1, 1'b0, 2, 6, "R3");
        if (r && !(oldv[2] && (pe - pe0[2] < 2))) set_ch(2, 1'b1, 1'b0, 2, 6, "R3");
        #1 txset = 0; rxset = 0;
    endtask

    task automatic set_stby(logic v);
        @(posedge clk); #1;
        stby = v;
        if (v) begin
            set_ch(3, 1'b0, 1'b1, 6, 8, "R7");
            set_ch(4, 1'b0, 1'b1, 6, 9, "R7");
        end else begin
            set_ch(3, 1'b1, 1'b0, 2, 3, "R8");
            set_ch(4, 1'b1, 1'b0, 0, 4, "R8");
        end
    endtask

    task automatic set_stat(logic e, logic d);
        @(negedge pcm_clk);
        ptxe = e; prxd = d;
        set_ch(5, newv[5], e, 0, 2, "R9");
        set_ch(6, newv[6], d, 0, 2, "R9");
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int tb, rb;
        for (int ch = 0; ch < 7; ch++) set_ch(ch, 1'b0, 1'b0, 0, 0, "R1");
        wait_clk(6);
        rst_n = 1; pcm_rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", sync_rd, 0); check("R1", txclr, 0); check("R1", rxclr, 0);
        check("R1", ready, 0);   check("R1", txe, 0);   check("R1", rxd, 0);
        check("R1", ptxclr, 0);  check("R1", prxclr, 0); check("R1", awake, 0);
        for (int ch = 0; ch < 7; ch++) pe0[ch] = pe;
        chk_en = 1;

        // R2: echo round trip, both values
        wr_echo(1); wait_clk(40); check("R2", sync_rd, 1);
        wr_echo(0); wait_clk(40); check("R2", sync_rd, 0);

        // R3/R4: transmit clear alone
        clr_req(1, 0); wait_clk(40);
        check("R4", tx_pulses[0], 1); check("R4", rx_pulses[0], 0);
        check("R4", tx_pulses == 1, 1);

        // R4: both together
        clr_req(1, 1); wait_clk(40);
        check("R4", tx_pulses == 2, 1); check("R4", rx_pulses == 1, 1);

        // R5: repeat request while pending
        clr_req(1, 0); clr_req(1, 0); wait_clk(40);
        check("R5", tx_pulses == 3, 1); check("R5", txclr, 0);

        // R6: stopped PCM clock holds pending work
        @(negedge pcm_raw); pcm_run = 0;
        rb = rx_pulses;
        clr_req(0, 1); wr_echo(1);
        wait_clk(100);
        check("R6", rxclr, 1); check("R6", sync_rd, 0); check("R6", rx_pulses == rb, 1);
        @(negedge pcm_raw); pcm_run = 1;
        wait_clk(40);
        check("R6", rxclr, 0); check("R6", sync_rd, 1); check("R6", rx_pulses == rb + 1, 1);

        // R7/R8: standby release and re-entry
        set_stby(1); wait_clk(60);
        check("R7", awake, 1); check("R7", ready, 1);
        set_stby(0); wait_clk(40);
        check("R8", awake, 0); check("R8", ready, 0);

        // R9: status patterns
        set_stat(1, 0); wait_clk(20); check("R9", txe, 1); check("R9", rxd, 0);
        set_stat(0, 1); wait_clk(20); check("R9", txe, 0); check("R9", rxd, 1);
        set_stat(1, 1); wait_clk(20); check("R9", txe, 1); check("R9", rxd, 1);
        tb = tx_pulses;
        check("R4", tb == 3, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule